// File: doc/BRIEF.md
# DMA Handshake Port with Programmable Pin Polarity

This block sits between an internal byte FIFO and an external DMA controller that moves data over a split 8-bit bus. It raises a request pin when the FIFO can take part in a transfer. A byte moves only while the controller holds its acknowledge active. Each byte is paced by a pulse. In strobe mode that pulse is a separate active-low strobe pin, qualified by acknowledge. In plain mode the acknowledge pulse itself paces the byte. Either way, the byte completes on the trailing edge of the pulse.

The end pin is bidirectional and its direction follows the transfer direction. When bytes flow into the FIFO (IN), the external side drives the end pin to report that the transfer is complete. When bytes flow out of the FIFO (OUT), the block drives the end pin during the pulse that carries the last byte. The request, acknowledge and end pins each have a configuration bit that selects active-low operation. All inputs from the pins pass through a reset-aware synchronizer. Inside the block, every signal is active high.

After an end event the request stays inactive until the port is disabled and enabled again. While disabled, the port drives nothing, requests nothing and moves no data.

Top module: `dma_hs_port`

## Requirements
- R1: `req_pin_o` equals the internal request XOR `cfg_req_low`, so an idle port shows 0 when `cfg_req_low`=0 and 1 when `cfg_req_low`=1.
- R2: With `cfg_dma_en`=1 and no end event since enable, the internal request is `fifo_space` when `cfg_dir_in`=1 and `fifo_avail` when `cfg_dir_in`=0.
- R3: A strobe with the acknowledge inactive moves no byte. The acknowledge is active when `ack_pin_i` XOR `cfg_ack_low` is 1.
- R4: With `cfg_rw_strobe`=1, each low pulse of `stb_pin_n_i` taken while acknowledge is active gives exactly one `fifo_wr_en` pulse in IN direction. `fifo_wr_data` then holds the byte present on `bus_i` during that strobe.
- R5: With `cfg_rw_strobe`=0, each acknowledge pulse on its own moves exactly one byte.
- R6: In OUT direction, `bus_oe` is 1 only during an active pulse and `bus_o` shows `fifo_rd_data`. Each completed pulse gives exactly one `fifo_rd_en` pulse.
- R7: In OUT direction, `end_pin_oe`=1. The end output is active (pin = 1 XOR `cfg_end_low`) during a pulse taken while `fifo_last`=1, and it returns inactive after that pulse's trailing edge. In IN direction, `end_pin_oe`=0.
- R8: In IN direction, an active level on `end_pin_i` (pin XOR `cfg_end_low` = 1) gives one `xfer_done` pulse. It also forces the request inactive until `cfg_dma_en` goes low.
- R9: In OUT direction, completing the last byte gives one `xfer_done` pulse and forces the request inactive.
- R10: With `cfg_dma_en`=0, there is no request, no byte movement, `bus_oe`=0 and `end_pin_oe`=0.
- R11: After reset, there is no FIFO write, no FIFO read, no `xfer_done` pulse, and both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_dma_en | input | 1 | 1 = split bus used for DMA; 0 = port idle |
| cfg_dir_in | input | 1 | 1 = IN (bytes into FIFO), 0 = OUT |
| cfg_rw_strobe | input | 1 | 1 = strobe pin paces bytes, 0 = acknowledge paces bytes |
| cfg_req_low | input | 1 | Request pin active low |
| cfg_ack_low | input | 1 | Acknowledge pin active low |
| cfg_end_low | input | 1 | End pin active low |
| req_pin_o | output | 1 | DMA request pin |
| ack_pin_i | input | 1 | DMA acknowledge pin |
| stb_pin_n_i | input | 1 | Data strobe pin, active low |
| end_pin_i | input | 1 | End pin, input side |
| end_pin_o | output | 1 | End pin, output side |
| end_pin_oe | output | 1 | End pin output enable |
| bus_i | input | 8 | Split data bus, input side |
| bus_o | output | 8 | Split data bus, output side |
| bus_oe | output | 1 | Split data bus output enable |
| fifo_space | input | 1 | FIFO can accept a byte |
| fifo_avail | input | 1 | FIFO holds a byte |
| fifo_last | input | 1 | FIFO head byte is the final one |
| fifo_rd_data | input | 8 | FIFO head byte |
| fifo_wr_en | output | 1 | FIFO write pulse |
| fifo_wr_data | output | 8 | Byte to write |
| fifo_rd_en | output | 1 | FIFO pop pulse |
| xfer_done | output | 1 | Transfer completion pulse |

## Verification
A wrong pulse register shows at the ports as a missing or doubled FIFO write or pop. This appears three clock edges after the strobe trailing edge at the pin: two synchronizer stages plus the state register. A stuck end-latch state shows as a request pin that never drops after an end event, or one that never returns after the port is disabled and enabled again. Because every pin goes through an XOR stage, a polarity fault inverts the idle level of the request or end pin. That inverted level is visible one edge after reset is released.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    typedef struct packed {
        logic pulse;     // paced transfer pulse, registered
        logic wr_en;     // FIFO write strobe
        logic rd_en;     // FIFO pop strobe
        logic req;       // internal active-high request
        logic end_out;   // internal active-high last-byte marker
        logic ended;     // end event seen since enable
        logic done;      // completion pulse
        logic end_seen;  // previous end-input level
    } hs_state_t;

endpackage

// File: rtl/dma_hs_sync.sv
module dma_hs_sync #(
    parameter int WIDTH  = 11,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= rst_val;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= rst_val;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dma_hs_pol.sv
module dma_hs_pol #(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] sig_i,
    input  logic [WIDTH-1:0] invert_i,
    output logic [WIDTH-1:0] sig_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign sig_o[b] = sig_i[b] ^ invert_i[b];
    end
endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
    import dma_hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dma_en,
    input  logic              cfg_dir_in,
    input  logic              cfg_rw_strobe,
    input  logic              ack_act,
    input  logic              stb_act,
    input  logic              end_in_act,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              fifo_space,
    input  logic              fifo_avail,
    input  logic              fifo_last,
    output logic              req_act,
    output logic              end_act,
    output logic              end_drive,
    output logic              bus_drive,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en,
    output logic              done
);
    hs_state_t         st_d, st_q;
    logic [DATA_W-1:0] data_d, data_q;
    logic              pulse_now, xfer, end_rise, last_out;

    always_comb begin
        st_d      = st_q;
        pulse_now = cfg_dma_en & (cfg_rw_strobe ? (ack_act & stb_act) : ack_act);
        xfer      = st_q.pulse & ~pulse_now;
        data_d    = pulse_now ? bus_data : data_q;

        st_d.pulse    = pulse_now;
        st_d.wr_en    = xfer & cfg_dir_in;
        st_d.rd_en    = xfer & ~cfg_dir_in;
        st_d.end_seen = cfg_dma_en & cfg_dir_in & end_in_act;
        end_rise      = st_d.end_seen & ~st_q.end_seen;
        last_out      = xfer & ~cfg_dir_in & fifo_last;
        st_d.done     = end_rise | last_out;
        st_d.ended    = cfg_dma_en & (st_q.ended | end_rise | last_out);
        st_d.req      = cfg_dma_en & ~st_d.ended & (cfg_dir_in ? fifo_space : fifo_avail);
        st_d.end_out  = cfg_dma_en & ~cfg_dir_in & pulse_now & fifo_last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            data_q <= '0;
        end else begin
            st_q   <= st_d;
            data_q <= data_d;
        end
    end

    assign req_act   = st_q.req;
    assign end_act   = st_q.end_out;
    assign end_drive = cfg_dma_en & ~cfg_dir_in;
    assign bus_drive = cfg_dma_en & ~cfg_dir_in & st_q.pulse;
    assign wr_en     = st_q.wr_en;
    assign wr_data   = data_q;
    assign rd_en     = st_q.rd_en;
    assign done      = st_q.done;

    // R3/R4/R6: a byte only completes after a pulse was registered
    a_r3_xfer_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr_en || st_q.rd_en) |-> $past(st_q.pulse));

    // R4/R5: one strobe per byte, never back to back
    a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |=> !st_q.wr_en);

    // R6: a read and a write never complete together
    a_r6_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.wr_en && st_q.rd_en));

    // R8/R9: completion pulse lasts one cycle and request is then inactive
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    a_r9_req_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.req);

    // R10: disabled port keeps request low one edge later
    a_r10_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dma_en |=> !st_q.req);
endmodule

// File: rtl/dma_hs_port.sv
module dma_hs_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dma_en,
    input  logic              cfg_dir_in,
    input  logic              cfg_rw_strobe,
    input  logic              cfg_req_low,
    input  logic              cfg_ack_low,
    input  logic              cfg_end_low,
    output logic              req_pin_o,
    input  logic              ack_pin_i,
    input  logic              stb_pin_n_i,
    input  logic              end_pin_i,
    output logic              end_pin_o,
    output logic              end_pin_oe,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe,
    input  logic              fifo_space,
    input  logic              fifo_avail,
    input  logic              fifo_last,
    input  logic [DATA_W-1:0] fifo_rd_data,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data,
    output logic              fifo_rd_en,
    output logic              xfer_done
);
    localparam int SYNC_W = DATA_W + 3;

    logic [SYNC_W-1:0] sync_in, sync_out, sync_rst;
    logic [2:0]        ctl_act;
    logic [1:0]        out_act, out_pin;
    logic              req_act, end_act;

    assign sync_in  = {ack_pin_i, stb_pin_n_i, end_pin_i, bus_i};
    assign sync_rst = {cfg_ack_low, 1'b1, cfg_end_low, {DATA_W{1'b0}}};

    dma_hs_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .rst_val(sync_rst),
        .async_i(sync_in), .sync_o(sync_out)
    );

    dma_hs_pol #(.WIDTH(3)) in_pol_i (
        .sig_i(sync_out[SYNC_W-1 -: 3]),
        .invert_i({cfg_ack_low, 1'b1, cfg_end_low}),
        .sig_o(ctl_act)
    );

    dma_hs_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_dma_en(cfg_dma_en), .cfg_dir_in(cfg_dir_in), .cfg_rw_strobe(cfg_rw_strobe),
        .ack_act(ctl_act[2]), .stb_act(ctl_act[1]), .end_in_act(ctl_act[0]),
        .bus_data(sync_out[DATA_W-1:0]),
        .fifo_space(fifo_space), .fifo_avail(fifo_avail), .fifo_last(fifo_last),
        .req_act(req_act), .end_act(end_act), .end_drive(end_pin_oe), .bus_drive(bus_oe),
        .wr_en(fifo_wr_en), .wr_data(fifo_wr_data), .rd_en(fifo_rd_en), .done(xfer_done)
    );

    assign out_act = {req_act, end_act};

    dma_hs_pol #(.WIDTH(2)) out_pol_i (
        .sig_i(out_act), .invert_i({cfg_req_low, cfg_end_low}), .sig_o(out_pin)
    );

    assign req_pin_o = out_pin[1];
    assign end_pin_o = out_pin[0];
    assign bus_o     = fifo_rd_data;

    // R7: end output only driven in OUT direction while enabled
    a_r7_end_dir: assert property (@(posedge clk) disable iff (!rst_n)
        end_pin_oe |-> (cfg_dma_en && !cfg_dir_in));
endmodule

// File: tb/dma_hs_port_tb_top.sv
module dma_hs_port_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, cfg_dma_en, cfg_dir_in, cfg_rw_strobe, cfg_req_low, cfg_ack_low, cfg_end_low;
    logic req_pin_o, ack_pin_i, stb_pin_n_i, end_pin_i, end_pin_o, end_pin_oe, bus_oe;
    logic [7:0] bus_i, bus_o, fifo_rd_data, fifo_wr_data;
    logic fifo_space, fifo_avail, fifo_last, fifo_wr_en, fifo_rd_en, xfer_done;

    int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0, done_cnt = 0;
    logic [7:0] wr_last;
    bit finished = 0;

    dma_hs_port dut_i (.*);

    always @(negedge clk) begin
        if (fifo_wr_en) begin wr_cnt++; wr_last = fifo_wr_data; end
        if (fifo_rd_en) rd_cnt++;
        if (xfer_done)  done_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one byte pulse; use_stb selects strobe pin, with_ack drives acknowledge
    task automatic pulse(input logic [7:0] d, input bit use_stb, input bit with_ack);
        bus_i = d;
        if (with_ack) ack_pin_i = ~cfg_ack_low;
        if (use_stb) stb_pin_n_i = 1'b0;
        wait_n(5);
        stb_pin_n_i = 1'b1;
        ack_pin_i   = cfg_ack_low;
        wait_n(6);
    endtask

    task automatic reenable();
        cfg_dma_en = 1'b0; wait_n(4); cfg_dma_en = 1'b1; wait_n(4);
    endtask

    // {dir_in, space, avail, req_low, expected pin}
    localparam logic [4:0] VEC [8] = '{
        5'b1_1_0_0_1, 5'b1_0_1_0_0, 5'b0_0_1_0_1, 5'b0_1_0_0_0,
        5'b1_1_0_1_0, 5'b1_0_0_1_1, 5'b0_0_1_1_0, 5'b0_1_1_1_0
    };

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_dma_en = 0; cfg_dir_in = 1; cfg_rw_strobe = 1;
        cfg_req_low = 0; cfg_ack_low = 0; cfg_end_low = 0;
        ack_pin_i = 0; stb_pin_n_i = 1; end_pin_i = 0; bus_i = 0;
        fifo_space = 0; fifo_avail = 0; fifo_last = 0; fifo_rd_data = 8'h00;
        wait_n(4); rst_n = 1; wait_n(3);

        // R11 / R1 reset state
        chk("R11 bus_oe", bus_oe, 0);
        chk("R11 end_oe", end_pin_oe, 0);
        chk("R11 no write", wr_cnt, 0);
        chk("R1 idle req", req_pin_o, 0);

        // R1/R2 table
        cfg_dma_en = 1;
        foreach (VEC[i]) begin
            cfg_dir_in = VEC[i][4]; fifo_space = VEC[i][3];
            fifo_avail = VEC[i][2]; cfg_req_low = VEC[i][1];
            wait_n(3);
            chk("R1 R2 req pin", req_pin_o, VEC[i][0]);
        end
        cfg_req_low = 0;

        // R4 IN strobe mode
        cfg_dir_in = 1; fifo_space = 1; wait_n(3);
        pulse(8'hA5, 1, 1);
        chk("R4 write count", wr_cnt, 1);
        chk("R4 write data", wr_last, 8'hA5);
        pulse(8'h3C, 1, 1);
        chk("R4 second write", wr_cnt, 2);
        chk("R4 second data", wr_last, 8'h3C);
        chk("R7 end_oe in IN", end_pin_oe, 0);

        // R3 strobe without acknowledge
        pulse(8'hFF, 1, 0);
        chk("R3 no ack no write", wr_cnt, 2);

        // R3 active-low acknowledge
        cfg_dma_en = 0; cfg_ack_low = 1; ack_pin_i = 1; wait_n(4); cfg_dma_en = 1; wait_n(3);
        pulse(8'h81, 1, 1);
        chk("R3 low ack write", wr_cnt, 3);
        chk("R3 low ack data", wr_last, 8'h81);
        cfg_dma_en = 0; cfg_ack_low = 0; ack_pin_i = 0; wait_n(4); cfg_dma_en = 1; wait_n(3);

        // R5 acknowledge-paced mode
        cfg_rw_strobe = 0;
        pulse(8'h5E, 0, 1);
        chk("R5 ack pulse write", wr_cnt, 4);
        chk("R5 ack pulse data", wr_last, 8'h5E);
        cfg_rw_strobe = 1;

        // R8 end input
        chk("R8 req before end", req_pin_o, 1);
        end_pin_i = 1; wait_n(6);
        chk("R8 done pulse", done_cnt, 1);
        chk("R8 req dropped", req_pin_o, 0);
        end_pin_i = 0; wait_n(4);
        chk("R8 req stays low", req_pin_o, 0);
        reenable();
        chk("R8 req after re-enable", req_pin_o, 1);

        // R6/R7 OUT direction
        cfg_dma_en = 0; cfg_dir_in = 0; fifo_avail = 1; fifo_rd_data = 8'h5A; wait_n(3);
        cfg_dma_en = 1; wait_n(3);
        chk("R7 end_oe in OUT", end_pin_oe, 1);
        bus_i = 8'h00; ack_pin_i = 1; stb_pin_n_i = 0; wait_n(5);
        chk("R6 bus_oe during strobe", bus_oe, 1);
        chk("R6 bus_o data", bus_o, 8'h5A);
        chk("R7 end inactive not last", end_pin_o, 0);
        stb_pin_n_i = 1; ack_pin_i = 0; wait_n(6);
        chk("R6 one pop", rd_cnt, 1);
        chk("R6 bus_oe released", bus_oe, 0);

        // R7/R9 last byte with active-low end
        cfg_dma_en = 0; cfg_end_low = 1; end_pin_i = 1; fifo_last = 1; wait_n(4);
        cfg_dma_en = 1; wait_n(3);
        chk("R7 end idle low-active", end_pin_o, 1);
        ack_pin_i = 1; stb_pin_n_i = 0; wait_n(5);
        chk("R7 end active on last", end_pin_o, 0);
        stb_pin_n_i = 1; ack_pin_i = 0; wait_n(6);
        chk("R7 end released", end_pin_o, 1);
        chk("R9 done on last", done_cnt, 2);
        chk("R9 req dropped", req_pin_o, 0);
        chk("R6 pop count", rd_cnt, 2);

        // R10 disabled port
        cfg_dma_en = 0; cfg_dir_in = 1; fifo_space = 1; cfg_end_low = 0; end_pin_i = 0; wait_n(4);
        pulse(8'h77, 1, 1);
        chk("R10 no write", wr_cnt, 4);
        chk("R10 no req", req_pin_o, 0);
        chk("R10 end_oe", end_pin_oe, 0);
        chk("R10 bus_oe", bus_oe, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule